// File: doc/BRIEF.md
# Reset and Oscillator Startup Sequencer

This block keeps a processor core in reset after any reset event until supply power is good and the chosen clock source has settled. Reset requests fall into two classes. Power-on and brown-out requests are cold; every other source, software reset included, is warm. A cold request reloads the active clock source from the configured selection. A warm request keeps the source the system is already running from.

Once power is good, the block runs only the startup stages that the active source needs, always in a fixed order. The first is a start-up delay timed on the reference clock. The second is a start-up timer that counts rising edges of the oscillator clock. The third is a PLL lock wait. When the last needed stage ends, the core leaves reset and the ready flag rises. A new request at any point starts the sequence again. All outputs are registered in the reference clock domain.

Top module: `rosc_seq_top`

## Requirements
- R1: On a cycle with `por_req` or `bor_req` high, the active source loads `cfg_src` at that edge. On a cycle with only warm requests high, it loads `cur_src`. In both cases `act_src` shows the new value one edge after the request.
- R2: When a cold request and a warm request arrive in the same cycle, the cold rule wins and `act_src` takes `cfg_src`.
- R3: `core_rst` stays high while `pwr_good` is low. If `pwr_good` drops before the sequence has finished, the sequence returns to its waiting state and starts again from the beginning once power is good.
- R4: Source codes and their stages:
  - 0 fast RC: delay only.
  - 1 fast RC with PLL: delay, then lock.
  - 2 XT crystal: delay, then timer.
  - 3 HS crystal: delay, then timer.
  - 4 secondary oscillator: delay, then timer.
  - 5 low-power RC: long delay.
  - 6 and 7 divided fast RC: delay only.
  - 8 external clock: no stages.
  - 9 external clock with PLL: lock only.
  - 10 XT with PLL and 11 HS with PLL: delay, then timer, then lock.
  - 12 to 15 behave as code 0.
- R5: The delay stage lasts exactly `OSD_CYCLES` reference cycles, or `OSD_LPRC_CYCLES` for code 5. With power good, `core_rst` falls 1+L edges after the request edge for a delay-only source of length L.
- R6: The timer stage ends after `OST_EDGES` rising edges of `osc_clk` seen during the stage. The count passes through a two-flop synchronizer, so the stage may run a few reference cycles longer than the edges alone take.
- R7: The lock stage lasts `PLL_CYCLES` reference cycles. It ends sooner, at the first stage cycle in which `pll_locked` is high.
- R8: Any request that arrives during a sequence, or after it has finished, raises `core_rst` at the next edge and restarts the sequence.
- R9: `clk_ready` is always the complement of `core_rst`. While `rst` is high, `core_rst` is 1 and `clk_ready` is 0.
- R10: For the external clock code with power good, `core_rst` falls one edge after the request edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running reference clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_clk | input | 1 | Clock of the selected oscillator |
| por_req | input | 1 | Power-on reset request (cold) |
| bor_req | input | 1 | Brown-out reset request (cold) |
| warm_req | input | NUM_WARM | Other reset requests (warm) |
| pwr_good | input | 1 | Supplies are at operating level |
| cfg_src | input | 4 | Configured source loaded on cold reset |
| cur_src | input | 4 | Currently running source kept on warm reset |
| pll_locked | input | 1 | PLL reports lock |
| core_rst | output | 1 | Core reset, active high |
| act_src | output | 4 | Active clock source code |
| clk_ready | output | 1 | Clock ready, core released |

## Verification
The assertions assume that requests, `pwr_good`, `cfg_src`, `cur_src` and `pll_locked` are synchronous to `clk`. They also assume `osc_clk` runs at less than half the reference rate, so that no oscillator edge is lost in the synchronizer. The bench changes all inputs on the falling reference edge and runs the oscillator at a quarter of the reference rate. It holds the selection inputs steady around every request. Timer-stage durations are checked against a small window rather than a single cycle, because the synchronizer latency depends on the phase between the two clocks.

// File: rtl/rosc_pkg.sv
package rosc_pkg;
  localparam int SRC_W = 4;

  typedef enum logic [2:0] {
    ST_HOLD = 3'd0,
    ST_OSD  = 3'd1,
    ST_OST  = 3'd2,
    ST_PLL  = 3'd3,
    ST_RUN  = 3'd4
  } seq_state_t;

  typedef struct packed {
    logic dly;
    logic tmr;
    logic pll;
    logic long_dly;
  } stage_plan_t;

  function automatic stage_plan_t plan_for(input logic [SRC_W-1:0] src);
    stage_plan_t p;
    p = '{dly: 1'b1, tmr: 1'b0, pll: 1'b0, long_dly: 1'b0};
    case (src)
      4'd1:        p = '{dly: 1'b1, tmr: 1'b0, pll: 1'b1, long_dly: 1'b0};
      4'd2, 4'd3,
      4'd4:        p = '{dly: 1'b1, tmr: 1'b1, pll: 1'b0, long_dly: 1'b0};
      4'd5:        p = '{dly: 1'b1, tmr: 1'b0, pll: 1'b0, long_dly: 1'b1};
      4'd8:        p = '{dly: 1'b0, tmr: 1'b0, pll: 1'b0, long_dly: 1'b0};
      4'd9:        p = '{dly: 1'b0, tmr: 1'b0, pll: 1'b1, long_dly: 1'b0};
      4'd10, 4'd11: p = '{dly: 1'b1, tmr: 1'b1, pll: 1'b1, long_dly: 1'b0};
      default:     p = '{dly: 1'b1, tmr: 1'b0, pll: 1'b0, long_dly: 1'b0};
    endcase
    return p;
  endfunction

  // Stage that follows 'cur' for the given plan, skipping unused stages.
  function automatic seq_state_t stage_after(input seq_state_t cur, input stage_plan_t p);
    seq_state_t n;
    n = ST_RUN;
    case (cur)
      ST_HOLD: n = p.dly ? ST_OSD : (p.tmr ? ST_OST : (p.pll ? ST_PLL : ST_RUN));
      ST_OSD:  n = p.tmr ? ST_OST : (p.pll ? ST_PLL : ST_RUN);
      ST_OST:  n = p.pll ? ST_PLL : ST_RUN;
      default: n = ST_RUN;
    endcase
    return n;
  endfunction
endpackage

// File: rtl/rosc_req_arb.sv
module rosc_req_arb
  import rosc_pkg::*;
#(
  parameter int NUM_WARM = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                por_req,
  input  logic                bor_req,
  input  logic [NUM_WARM-1:0] warm_req,
  input  logic [SRC_W-1:0]    cfg_src,
  input  logic [SRC_W-1:0]    cur_src,
  output logic                restart,
  output logic [SRC_W-1:0]    act_src
);
  logic cold_hit;
  logic warm_hit;

  assign cold_hit = por_req | bor_req;
  assign warm_hit = |warm_req;
  assign restart  = cold_hit | warm_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_src <= cfg_src;
    end else if (cold_hit) begin
      act_src <= cfg_src;
    end else if (warm_hit) begin
      act_src <= cur_src;
    end
  end

  // R1 / R2: cold requests reload the configured source, even with a warm request alongside
  assert_cold_src_R1: assert property (@(posedge clk) disable iff (rst)
    (por_req || bor_req) |=> (act_src == $past(cfg_src)));

  // R1: a warm request on its own keeps the running source
  assert_warm_src_R1: assert property (@(posedge clk) disable iff (rst)
    (!por_req && !bor_req && (|warm_req)) |=> (act_src == $past(cur_src)));
endmodule

// File: rtl/rosc_delay_timer.sv
module rosc_delay_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [CNT_W-1:0] length_m1,
  input  logic             early,
  output logic             done
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (cnt != length_m1) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign done = run && ((cnt == length_m1) || early);

  // R5 / R7: the sequencer leaves a timed stage as soon as it ends
  assert_stage_exit_R5: assert property (@(posedge clk) disable iff (rst)
    done |=> !run);
endmodule

// File: rtl/rosc_osc_edge_cnt.sv
module rosc_osc_edge_cnt #(
  parameter int EDGES = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic osc_clk,
  input  logic run,
  output logic done
);
  localparam int CW = $clog2(EDGES + 1);
  localparam logic [CW-1:0] TARGET = CW'(EDGES);

  logic          osc_tog = 1'b0;
  logic          sync_a;
  logic          sync_b;
  logic          sync_c;
  logic          edge_seen;
  logic [CW-1:0] cnt;

  always_ff @(posedge osc_clk) begin
    osc_tog <= ~osc_tog;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_a <= 1'b0;
      sync_b <= 1'b0;
      sync_c <= 1'b0;
    end else begin
      sync_a <= osc_tog;
      sync_b <= sync_a;
      sync_c <= sync_b;
    end
  end

  assign edge_seen = sync_b ^ sync_c;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (edge_seen && (cnt != TARGET)) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign done = run && (cnt == TARGET);

  // R6: the sequencer leaves the timer stage once the edge count is reached
  assert_timer_exit_R6: assert property (@(posedge clk) disable iff (rst)
    done |=> !run);
endmodule

// File: rtl/rosc_seq_top.sv
module rosc_seq_top
  import rosc_pkg::*;
#(
  parameter int NUM_WARM        = 3,
  parameter int OSD_CYCLES      = 138,
  parameter int OSD_LPRC_CYCLES = 8750,
  parameter int PLL_CYCLES      = 187500,
  parameter int OST_EDGES       = 1024
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                osc_clk,
  input  logic                por_req,
  input  logic                bor_req,
  input  logic [NUM_WARM-1:0] warm_req,
  input  logic                pwr_good,
  input  logic [SRC_W-1:0]    cfg_src,
  input  logic [SRC_W-1:0]    cur_src,
  input  logic                pll_locked,
  output logic                core_rst,
  output logic [SRC_W-1:0]    act_src,
  output logic                clk_ready
);
  localparam int MAX_DLY = (OSD_CYCLES > OSD_LPRC_CYCLES) ? OSD_CYCLES : OSD_LPRC_CYCLES;
  localparam int MAX_LEN = (MAX_DLY > PLL_CYCLES) ? MAX_DLY : PLL_CYCLES;
  localparam int TMR_W   = $clog2(MAX_LEN) + 1;
  localparam logic [TMR_W-1:0] OSD_M1  = TMR_W'(OSD_CYCLES - 1);
  localparam logic [TMR_W-1:0] LPRC_M1 = TMR_W'(OSD_LPRC_CYCLES - 1);
  localparam logic [TMR_W-1:0] PLL_M1  = TMR_W'(PLL_CYCLES - 1);

  seq_state_t       state;
  seq_state_t       nxt;
  stage_plan_t      plan;
  logic             restart;
  logic             dly_done;
  logic             tmr_done;
  logic             pll_done;
  logic [TMR_W-1:0] dly_len;

  rosc_req_arb #(.NUM_WARM(NUM_WARM)) u_arb (
    .clk      (clk),
    .rst      (rst),
    .por_req  (por_req),
    .bor_req  (bor_req),
    .warm_req (warm_req),
    .cfg_src  (cfg_src),
    .cur_src  (cur_src),
    .restart  (restart),
    .act_src  (act_src)
  );

  assign plan    = plan_for(act_src);
  assign dly_len = plan.long_dly ? LPRC_M1 : OSD_M1;

  rosc_delay_timer #(.CNT_W(TMR_W)) u_dly (
    .clk       (clk),
    .rst       (rst),
    .run       (state == ST_OSD),
    .length_m1 (dly_len),
    .early     (1'b0),
    .done      (dly_done)
  );

  rosc_osc_edge_cnt #(.EDGES(OST_EDGES)) u_ost (
    .clk     (clk),
    .rst     (rst),
    .osc_clk (osc_clk),
    .run     (state == ST_OST),
    .done    (tmr_done)
  );

  rosc_delay_timer #(.CNT_W(TMR_W)) u_pll (
    .clk       (clk),
    .rst       (rst),
    .run       (state == ST_PLL),
    .length_m1 (PLL_M1),
    .early     (pll_locked),
    .done      (pll_done)
  );

  always_comb begin
    nxt = state;
    case (state)
      ST_HOLD: if (pwr_good) nxt = stage_after(ST_HOLD, plan);
      ST_OSD:  if (dly_done) nxt = stage_after(ST_OSD, plan);
      ST_OST:  if (tmr_done) nxt = stage_after(ST_OST, plan);
      ST_PLL:  if (pll_done) nxt = ST_RUN;
      default: nxt = ST_RUN;
    endcase
    if (restart) begin
      nxt = ST_HOLD;
    end else if (!pwr_good && (state != ST_RUN)) begin
      nxt = ST_HOLD;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_HOLD;
      core_rst  <= 1'b1;
      clk_ready <= 1'b0;
    end else begin
      state     <= nxt;
      core_rst  <= (nxt != ST_RUN);
      clk_ready <= (nxt == ST_RUN);
    end
  end

  // R8: every request puts the core back in reset at the next edge
  assert_restart_R8: assert property (@(posedge clk) disable iff (rst)
    (por_req || bor_req || (|warm_req)) |=> core_rst);

  // R3: no release while power is not good
  assert_hold_power_R3: assert property (@(posedge clk) disable iff (rst)
    (core_rst && !pwr_good) |=> core_rst);

  // R9: ready is never raised together with reset
  assert_ready_excl_R9: assert property (@(posedge clk) disable iff (rst)
    core_rst != clk_ready);
endmodule

// File: tb/test_rosc_seq_top.sv
module test_rosc_seq_top;
  localparam int OSD  = 20;
  localparam int LPRC = 35;
  localparam int PLL  = 50;
  localparam int OST  = 1024;
  localparam int OSTC = OST * 4;

  logic       clk = 1'b0;
  logic       osc_clk = 1'b0;
  logic       rst = 1'b1;
  logic       por_req = 1'b0;
  logic       bor_req = 1'b0;
  logic [2:0] warm_req = '0;
  logic       pwr_good = 1'b0;
  logic [3:0] cfg_src = 4'd0;
  logic [3:0] cur_src = 4'd0;
  logic       pll_locked = 1'b0;
  logic       core_rst;
  logic [3:0] act_src;
  logic       clk_ready;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;
  always #16 osc_clk = ~osc_clk;

  rosc_seq_top #(
    .NUM_WARM(3), .OSD_CYCLES(OSD), .OSD_LPRC_CYCLES(LPRC),
    .PLL_CYCLES(PLL), .OST_EDGES(OST)
  ) i_rosc_seq_top (
    .clk(clk), .rst(rst), .osc_clk(osc_clk), .por_req(por_req), .bor_req(bor_req),
    .warm_req(warm_req), .pwr_good(pwr_good), .cfg_src(cfg_src), .cur_src(cur_src),
    .pll_locked(pll_locked), .core_rst(core_rst), .act_src(act_src), .clk_ready(clk_ready)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_win(input string req, input int act, input int lo, input int hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  // Edges until core_rst is seen low, sampled on falling edges.
  task automatic measure(output int n);
    n = 0;
    while (core_rst && n < 20000) begin
      @(posedge clk);
      n++;
      @(negedge clk);
    end
    chk("R9 ready after release", int'(clk_ready), 1);
  endtask

  // Pulse one request for one cycle; leaves the bench at the negedge after it.
  task automatic pulse(input bit por, input bit bor, input logic [2:0] warm);
    @(negedge clk);
    por_req = por; bor_req = bor; warm_req = warm;
    @(posedge clk);
    @(negedge clk);
    por_req = 1'b0; bor_req = 1'b0; warm_req = '0;
  endtask

  task automatic t_reset_and_power;
    int n;
    @(negedge clk);
    chk("R9 reset core_rst", int'(core_rst), 1);
    chk("R9 reset clk_ready", int'(clk_ready), 0);
    rst = 1'b0;
    repeat (100) @(negedge clk);
    chk("R3 held without power", int'(core_rst), 1);
    pwr_good = 1'b1;
    measure(n);
    chk("R5 first release fast RC", n, 1 + OSD);
  endtask

  task automatic t_cold_lprc_bor;
    int n;
    cfg_src = 4'd5; cur_src = 4'd0;
    pulse(1'b0, 1'b1, 3'b000);
    chk("R1 brown-out loads configured", int'(act_src), 5);
    measure(n);
    chk("R5 low-power RC long delay", n, 1 + LPRC);
  endtask

  task automatic t_ext_clock;
    int n;
    cfg_src = 4'd8;
    pulse(1'b1, 1'b0, 3'b000);
    chk("R1 power-on loads configured", int'(act_src), 8);
    measure(n);
    chk("R10 external clock no delay", n, 1);
  endtask

  task automatic t_ext_pll;
    int n;
    cfg_src = 4'd9; pll_locked = 1'b0;
    pulse(1'b1, 1'b0, 3'b000);
    measure(n);
    chk("R7 lock wait full length", n, 1 + PLL);
    pll_locked = 1'b1;
    pulse(1'b1, 1'b0, 3'b000);
    measure(n);
    chk("R7 lock ends early", n, 2);
    pll_locked = 1'b0;
  endtask

  task automatic t_frc_pll;
    int n;
    cfg_src = 4'd1;
    pulse(1'b1, 1'b0, 3'b000);
    measure(n);
    chk("R4 fast RC with PLL delay then lock", n, 1 + OSD + PLL);
  endtask

  task automatic t_warm;
    int n;
    cfg_src = 4'd8; cur_src = 4'd0;
    pulse(1'b0, 1'b0, 3'b010);
    chk("R1 warm keeps running source", int'(act_src), 0);
    measure(n);
    chk("R5 warm fast RC delay", n, 1 + OSD);
  endtask

  task automatic t_priority;
    int n;
    cfg_src = 4'd8; cur_src = 4'd5;
    pulse(1'b1, 1'b0, 3'b100);
    chk("R2 cold wins over warm", int'(act_src), 8);
    measure(n);
    chk("R2 release follows configured", n, 1);
  endtask

  task automatic t_restart;
    int n;
    cfg_src = 4'd1; cur_src = 4'd1;
    pulse(1'b1, 1'b0, 3'b000);
    repeat (30) @(negedge clk);
    chk("R8 still in sequence", int'(core_rst), 1);
    pulse(1'b0, 1'b0, 3'b001);
    measure(n);
    chk("R8 restart from beginning", n, 1 + OSD + PLL);
    pulse(1'b0, 1'b0, 3'b001);
    chk("R8 request after release", int'(core_rst), 1);
    measure(n);
    chk("R8 second restart", n, 1 + OSD + PLL);
  endtask

  task automatic t_power_drop;
    int n;
    cfg_src = 4'd0;
    pulse(1'b1, 1'b0, 3'b000);
    repeat (10) @(negedge clk);
    pwr_good = 1'b0;
    repeat (15) @(negedge clk);
    chk("R3 held after power drop", int'(core_rst), 1);
    pwr_good = 1'b1;
    measure(n);
    chk("R3 sequence starts over", n, 1 + OSD);
  endtask

  task automatic t_crystal;
    int n;
    cfg_src = 4'd2; pll_locked = 1'b0;
    pulse(1'b1, 1'b0, 3'b000);
    measure(n);
    chk_win("R6 XT delay then timer", n, 1 + OSD + OSTC - 6, 1 + OSD + OSTC + 6);
    cfg_src = 4'd11; pll_locked = 1'b1;
    pulse(1'b1, 1'b0, 3'b000);
    measure(n);
    chk_win("R4 HS PLL three stages", n, 2 + OSD + OSTC - 6, 2 + OSD + OSTC + 6);
    pll_locked = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset_and_power();
    t_cold_lprc_bor();
    t_ext_clock();
    t_ext_pll();
    t_frc_pll();
    t_warm();
    t_priority();
    t_restart();
    t_power_drop();
    t_crystal();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule